// File: doc/BRIEF.md
# Multi-Context Configuration Sequencer

This block sits beside a processor pipeline and a reconfigurable array. When the pipeline reaches a custom instruction, it presents the instruction's identifier together with a slack value. The slack is the number of cycles that can be spent before the original code would have to take over. The sequencer keeps a small bank of configuration contexts, each tagged with the identifier it holds. On each request it picks one of three outcomes: run the instruction at once from a resident context; copy the configuration in from a larger configuration cache and then run it; or signal that the fetch unit should continue with the ordinary instruction sequence.

A configuration is wider than the cache read path, so a load is a fixed run of beats. A load is started only when the slack covers every beat. While the array runs, the sequencer steers register-file read addresses from configuration memory instead of the decoder. It also steers writeback from the array instead of the normal functional unit. It holds both selects until the array reports completion. A new configuration goes into an empty context if one exists, and otherwise replaces the context used least recently.

Top module: `cfg_ctx_sequencer`

## Requirements
- R1: After reset `req_ready` is 1, `exec_start`, `fallback`, `cache_rd_en`, `rf_sel_cfg` and `wb_sel_array` are 0, and no context holds a valid configuration.
- R2: A request whose `req_id` matches a valid context tag pulses `exec_start` in the cycle after the request, with `exec_ctx` naming that context, whatever the slack, and with no cache read.
- R3: A request that misses with `req_slack` at least LOAD_BEATS (CFG_BITS/BUS_W, 8 by default) starts a load. `cache_rd_en` is high for exactly LOAD_BEATS consecutive cycles starting the cycle after the request, with `cache_rd_id` equal to the request ID and `cache_rd_beat` counting 0 up to LOAD_BEATS-1. `exec_start` pulses in the cycle after the last beat.
- R4: A request that misses with `req_slack` below LOAD_BEATS produces a one-cycle `fallback` pulse in the cycle after the request. It starts no cache read and leaves every context unchanged.
- R5: A load goes into the lowest-numbered empty context. When all contexts are full, it goes into the least recently used context, where both hits and loads count as uses. An evicted ID misses afterwards.
- R6: From the `exec_start` cycle until the cycle after `array_done` is sampled high, `rf_sel_cfg` is 1 (register reads addressed from configuration memory; 0 means decoder) and `wb_sel_array` is 1 (writeback from the array; 0 means functional unit). Both are 0 otherwise.
- R7: `req_ready` is 0 during a load and during execution. A request presented then is ignored and loads nothing.
- R8: While executing, `cfg_active` holds the configuration of context `exec_ctx`. The cache word returned for beat k is placed at bits [k*BUS_W+BUS_W-1 : k*BUS_W].
- R9: `exec_start` and `fallback` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Custom-instruction request strobe |
| req_id | input | ID_W | Custom-instruction identifier |
| req_slack | input | SLACK_W | Cycles available before the original code must run |
| req_ready | output | 1 | Sequencer idle and accepting requests |
| exec_start | output | 1 | Pulse: array execution begins |
| exec_ctx | output | CTX_W | Context used by the array |
| fallback | output | 1 | Pulse: run the original instruction sequence |
| array_done | input | 1 | Array has finished the current instruction |
| rf_sel_cfg | output | 1 | 1: register read addresses from configuration memory |
| wb_sel_array | output | 1 | 1: writeback from the array |
| cache_rd_en | output | 1 | Configuration cache read strobe |
| cache_rd_id | output | ID_W | Identifier being read from the cache |
| cache_rd_beat | output | BEAT_W | Beat index of the cache read |
| cache_rd_data | input | BUS_W | Cache word for the current beat, same cycle |
| cfg_active | output | CFG_BITS | Configuration of the selected context |

## Verification
The bench builds the sequencer with its defaults: four contexts, 8-bit IDs and slack, and 512-bit configurations over a 64-bit path, which gives eight-beat loads. Four contexts let the bench fill every slot, refresh the oldest with a hit, and then force an eviction whose victim differs from plain rotation. The 8-bit slack reaches the 7/8 threshold, a slack of zero on hits, and a large slack on a request sent while the sequencer is busy.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_EXEC = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ctx_tag_lookup.sv
module ctx_tag_lookup #(
  parameter int NUM_CTX = 4,
  parameter int ID_W    = 8,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [CTX_W-1:0] set_idx,
  input  logic [ID_W-1:0]  set_tag,
  input  logic             clr_en,
  input  logic [CTX_W-1:0] clr_idx,
  input  logic [ID_W-1:0]  look_id,
  output logic             hit,
  output logic [CTX_W-1:0] hit_idx,
  output logic             any_free,
  output logic [CTX_W-1:0] free_idx
);
  logic [NUM_CTX-1:0] valid_q, valid_d;
  logic [ID_W-1:0]    tag_q [NUM_CTX];
  logic [NUM_CTX-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_CTX; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_id);
      always_ff @(posedge clk) begin
        if (set_en && (set_idx == CTX_W'(g))) tag_q[g] <= set_tag;
      end
    end
  endgenerate

  always_comb begin
    valid_d = valid_q;
    if (clr_en) valid_d[clr_idx] = 1'b0;
    if (set_en) valid_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                valid_q <= '0;
    else if (set_en || clr_en) valid_q <= valid_d;
  end

  always_comb begin
    hit      = |hit_vec;
    hit_idx  = '0;
    any_free = ~&valid_q;
    free_idx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx  = CTX_W'(i);
      if (!valid_q[i]) free_idx = CTX_W'(i);
    end
  end

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/ctx_lru.sv
module ctx_lru #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [CTX_W-1:0] touch_idx,
  output logic [CTX_W-1:0] lru_idx
);
  localparam logic [CTX_W-1:0] OLDEST = CTX_W'(NUM_CTX - 1);

  logic [CTX_W-1:0]   age_q [NUM_CTX];
  logic [CTX_W-1:0]   age_d [NUM_CTX];
  logic [NUM_CTX-1:0] oldest_vec;

  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      age_d[i] = age_q[i];
      if (CTX_W'(i) == touch_idx)          age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTX; i++) age_q[i] <= CTX_W'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      oldest_vec[i] = (age_q[i] == OLDEST);
      if (oldest_vec[i]) lru_idx = CTX_W'(i);
    end
  end

  // R5
  lru_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R5
  lru_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/ctx_cfg_store.sv
module ctx_cfg_store #(
  parameter int NUM_CTX  = 4,
  parameter int CFG_BITS = 512,
  parameter int BUS_W    = 64,
  parameter int CTX_W    = $clog2(NUM_CTX),
  parameter int BEATS    = CFG_BITS / BUS_W,
  parameter int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [CTX_W-1:0]    wr_ctx,
  input  logic [BEAT_W-1:0]   wr_beat,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic [CTX_W-1:0]    rd_ctx,
  output logic [CFG_BITS-1:0] rd_data
);
  logic [BUS_W-1:0] mem_q [NUM_CTX][BEATS];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int b = 0; b < BEATS; b++) begin
        if (wr_en && (wr_ctx == CTX_W'(c)) && (wr_beat == BEAT_W'(b)))
          mem_q[c][b] <= wr_data;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BEATS; b++) rd_data[b*BUS_W +: BUS_W] = mem_q[rd_ctx][b];
  end

endmodule

// File: rtl/cfg_ctx_sequencer.sv
module cfg_ctx_sequencer
  import ctx_seq_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int ID_W     = 8,
  parameter int SLACK_W  = 8,
  parameter int CFG_BITS = 512,
  parameter int BUS_W    = 64,
  parameter int CTX_W    = $clog2(NUM_CTX),
  parameter int BEATS    = CFG_BITS / BUS_W,
  parameter int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ID_W-1:0]     req_id,
  input  logic [SLACK_W-1:0]  req_slack,
  output logic                req_ready,
  output logic                exec_start,
  output logic [CTX_W-1:0]    exec_ctx,
  output logic                fallback,
  input  logic                array_done,
  output logic                rf_sel_cfg,
  output logic                wb_sel_array,
  output logic                cache_rd_en,
  output logic [ID_W-1:0]     cache_rd_id,
  output logic [BEAT_W-1:0]   cache_rd_beat,
  input  logic [BUS_W-1:0]    cache_rd_data,
  output logic [CFG_BITS-1:0] cfg_active
);
  localparam logic [SLACK_W-1:0] MIN_SLACK = SLACK_W'(BEATS);
  localparam logic [BEAT_W-1:0]  LAST_BEAT = BEAT_W'(BEATS - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  seq_state_e        state_q, state_d;
  logic [CTX_W-1:0]  act_q, act_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ID_W-1:0]   load_id_q, load_id_d;
  logic              start_q, start_d;
  logic              fb_q, fb_d;

  logic              hit, any_free;
  logic [CTX_W-1:0]  hit_idx, free_idx, lru_idx, victim;
  logic              tag_set, tag_clr, touch_en;
  logic [CTX_W-1:0]  touch_idx;
  logic              accept, can_load, loading;

  assign accept   = req_valid && (state_q == SEQ_IDLE);
  assign can_load = (req_slack >= MIN_SLACK);
  assign victim   = any_free ? free_idx : lru_idx;
  assign loading  = (state_q == SEQ_LOAD);

  ctx_tag_lookup #(.NUM_CTX(NUM_CTX), .ID_W(ID_W), .CTX_W(CTX_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_q),
    .set_en   (tag_set),
    .set_idx  (act_q),
    .set_tag  (load_id_q),
    .clr_en   (tag_clr),
    .clr_idx  (victim),
    .look_id  (req_id),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  ctx_lru #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_q),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  ctx_cfg_store #(.NUM_CTX(NUM_CTX), .CFG_BITS(CFG_BITS), .BUS_W(BUS_W),
                  .CTX_W(CTX_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_store (
    .clk     (clk),
    .wr_en   (loading),
    .wr_ctx  (act_q),
    .wr_beat (beat_q),
    .wr_data (cache_rd_data),
    .rd_ctx  (act_q),
    .rd_data (cfg_active)
  );

  // next state
  always_comb begin
    state_d   = state_q;
    act_d     = act_q;
    beat_d    = beat_q;
    load_id_d = load_id_q;
    start_d   = 1'b0;
    fb_d      = 1'b0;
    tag_set   = 1'b0;
    tag_clr   = 1'b0;
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (hit) begin
            state_d  = SEQ_EXEC;
            start_d  = 1'b1;
            act_d    = hit_idx;
            touch_en = 1'b1;
          end else if (can_load) begin
            state_d   = SEQ_LOAD;
            act_d     = victim;
            beat_d    = '0;
            load_id_d = req_id;
            tag_clr   = 1'b1;
            touch_en  = 1'b1;
            touch_idx = victim;
          end else begin
            fb_d = 1'b1;
          end
        end
      end
      SEQ_LOAD: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) begin
          state_d = SEQ_EXEC;
          start_d = 1'b1;
          tag_set = 1'b1;
          beat_d  = '0;
        end
      end
      SEQ_EXEC: begin
        if (array_done) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q   <= SEQ_IDLE;
      act_q     <= '0;
      beat_q    <= '0;
      load_id_q <= '0;
      start_q   <= 1'b0;
      fb_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      fb_q    <= fb_d;
      if (accept || loading) begin
        act_q     <= act_d;
        beat_q    <= beat_d;
        load_id_q <= load_id_d;
      end
    end
  end

  assign req_ready     = (state_q == SEQ_IDLE);
  assign exec_start    = start_q;
  assign exec_ctx      = act_q;
  assign fallback      = fb_q;
  assign rf_sel_cfg    = (state_q == SEQ_EXEC);
  assign wb_sel_array  = (state_q == SEQ_EXEC);
  assign cache_rd_en   = loading;
  assign cache_rd_id   = load_id_q;
  assign cache_rd_beat = beat_q;

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(exec_start && fallback));

  // R4
  fb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fallback |=> !fallback);

  // R4
  fb_slack_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fallback |-> ($past(req_slack) < MIN_SLACK) && !cache_rd_en);

  // R3
  load_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(cache_rd_en) |-> (cache_rd_beat == '0));

  // R3
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(cache_rd_en) |-> exec_start && ($past(cache_rd_beat) == LAST_BEAT));

  // R3
  load_id_stable_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cache_rd_en && $past(cache_rd_en)) |-> $stable(cache_rd_id));

  // R6
  sel_on_start_chk: assert property (@(posedge clk) disable iff (!rst_q)
    exec_start |-> rf_sel_cfg && wb_sel_array && !req_ready);

  // R6
  sel_release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(rf_sel_cfg) |-> $past(array_done) && req_ready);

endmodule

// File: tb/sim_cfg_ctx_sequencer.sv
module sim_cfg_ctx_sequencer;
  localparam int NUM_CTX = 4, ID_W = 8, SLACK_W = 8, CFG_BITS = 512, BUS_W = 64;
  localparam int CTX_W = 2, BEATS = 8, BEAT_W = 3;

  logic clk, rst_n;
  logic req_valid, array_done;
  logic [ID_W-1:0] req_id;
  logic [SLACK_W-1:0] req_slack;
  logic req_ready, exec_start, fallback, rf_sel_cfg, wb_sel_array, cache_rd_en;
  logic [CTX_W-1:0] exec_ctx;
  logic [ID_W-1:0] cache_rd_id;
  logic [BEAT_W-1:0] cache_rd_beat;
  logic [BUS_W-1:0] cache_rd_data;
  logic [CFG_BITS-1:0] cfg_active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  cfg_ctx_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_slack(req_slack), .req_ready(req_ready), .exec_start(exec_start),
    .exec_ctx(exec_ctx), .fallback(fallback), .array_done(array_done),
    .rf_sel_cfg(rf_sel_cfg), .wb_sel_array(wb_sel_array),
    .cache_rd_en(cache_rd_en), .cache_rd_id(cache_rd_id),
    .cache_rd_beat(cache_rd_beat), .cache_rd_data(cache_rd_data),
    .cfg_active(cfg_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [BUS_W-1:0] word_of(input logic [ID_W-1:0] id, input int beat);
    return {id, 5'd0, BEAT_W'(beat), 48'h5A5A_C3C3_0000 ^ {40'd0, id}};
  endfunction

  assign cache_rd_data = word_of(cache_rd_id, int'(cache_rd_beat));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [ID_W-1:0] id, input logic [SLACK_W-1:0] slack);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_slack = slack;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_cfg(input logic [ID_W-1:0] id);
    for (int b = 0; b < BEATS; b++)
      chk(cfg_active[b*BUS_W +: BUS_W] == word_of(id, b), "R8 cfg_active beat",
          cfg_active[b*BUS_W +: BUS_W], word_of(id, b));
  endtask

  task automatic finish_exec();
    chk(rf_sel_cfg && wb_sel_array, "R6 selects during exec", {rf_sel_cfg, wb_sel_array}, 2'b11);
    @(negedge clk);
    chk(rf_sel_cfg && wb_sel_array && !exec_start, "R6 R9 held, pulse ends",
        {rf_sel_cfg, wb_sel_array, exec_start}, 3'b110);
    array_done = 1'b1;
    @(negedge clk);
    array_done = 1'b0;
    chk(!rf_sel_cfg && !wb_sel_array && req_ready, "R6 released after done",
        {rf_sel_cfg, wb_sel_array, req_ready}, 3'b001);
  endtask

  task automatic t_hit(input logic [ID_W-1:0] id, input logic [SLACK_W-1:0] slack, input int ctx);
    send(id, slack);
    chk(exec_start && !fallback && !cache_rd_en, "R2 hit starts at once",
        {exec_start, fallback, cache_rd_en}, 3'b100);
    chk(exec_ctx == CTX_W'(ctx), "R2 hit context", exec_ctx, ctx);
    check_cfg(id);
    finish_exec();
  endtask

  task automatic t_fallback(input logic [ID_W-1:0] id, input logic [SLACK_W-1:0] slack);
    send(id, slack);
    chk(fallback && !exec_start && !cache_rd_en && req_ready, "R4 fallback pulse",
        {fallback, exec_start, cache_rd_en, req_ready}, 4'b1001);
    @(negedge clk);
    chk(!fallback && !cache_rd_en, "R4 R9 fallback one cycle", {fallback, cache_rd_en}, 2'b00);
  endtask

  task automatic t_load(input logic [ID_W-1:0] id, input logic [SLACK_W-1:0] slack,
                        input int ctx, input bit intrude);
    send(id, slack);
    for (int k = 0; k < BEATS; k++) begin
      chk(cache_rd_en && cache_rd_beat == BEAT_W'(k) && cache_rd_id == id, "R3 load beat",
          {cache_rd_en, cache_rd_id, 5'd0, cache_rd_beat}, {1'b1, id, 5'd0, BEAT_W'(k)});
      chk(!req_ready && !exec_start && !fallback, "R7 busy while loading",
          {req_ready, exec_start, fallback}, 3'b000);
      if (intrude && k == 3) begin
        req_valid = 1'b1; req_id = 8'h55; req_slack = 8'd200;
      end
      if (k == 4) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(!cache_rd_en && exec_start, "R3 exec after last beat", {cache_rd_en, exec_start}, 2'b01);
    chk(exec_ctx == CTX_W'(ctx), "R5 victim context", exec_ctx, ctx);
    check_cfg(id);
    finish_exec();
  endtask

  task automatic t_busy_exec();
    send(8'h10, 8'd0);
    req_valid = 1'b1; req_id = 8'h66; req_slack = 8'd255;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!cache_rd_en && !fallback && !req_ready, "R7 request during exec ignored",
        {cache_rd_en, fallback, req_ready}, 3'b000);
    finish_exec();
    @(negedge clk);
    chk(!cache_rd_en && !exec_start && !fallback, "R7 nothing queued",
        {cache_rd_en, exec_start, fallback}, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_slack = '0; array_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(req_ready && !exec_start && !fallback && !cache_rd_en && !rf_sel_cfg && !wb_sel_array,
        "R1 reset state", {req_ready, exec_start, fallback, cache_rd_en, rf_sel_cfg, wb_sel_array},
        6'b100000);
    t_fallback(8'h10, 8'd3);       // R1 nothing resident, R4
    t_fallback(8'h10, 8'd7);       // R4 boundary just below
    t_load(8'h10, 8'd8, 0, 1'b0);  // R3 boundary, R5 empty slot 0
    t_hit(8'h10, 8'd0, 0);         // R2 with zero slack
    t_load(8'h11, 8'd40, 1, 1'b1); // R7 intrusion during load
    t_fallback(8'h55, 8'd0);       // R7 intruder not loaded
    t_load(8'h12, 8'd9, 2, 1'b0);
    t_load(8'h13, 8'd255, 3, 1'b0);
    t_hit(8'h10, 8'd1, 0);         // refresh ctx 0 -> oldest is ctx 1
    t_load(8'h14, 8'd8, 1, 1'b0);  // R5 LRU eviction
    t_fallback(8'h11, 8'd0);       // R5 evicted id misses
    t_hit(8'h12, 8'd0, 2);         // R8 untouched context intact
    t_hit(8'h13, 8'd0, 3);
    t_busy_exec();                 // R7 during execution
    t_hit(8'h14, 8'd0, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule